// File: doc/BRIEF.md
# Dual-Ring Snoop Response Combiner

This block is the per-node piece of a coherency fabric built on two rings that run in opposite directions. Ring 0 carries traffic from node i to node i+1 and ring 1 carries it from node i to node i-1, both modulo the node count. A node that starts a snoop puts the command, tag and address on both rings in one cycle. Every other node sees the snoop twice, once on each ring. Each time, it folds its own directory answer into the response travelling on that ring and passes the result on to its neighbour one cycle later. When the snoop comes back to the node that started it, that node takes the response off the ring and does not pass it on.

Whichever ring delivers a snoop to a node first, the node forwards a partial, early response on that ring. On the ring that delivers it second, the node forwards a final response. The final response also folds in the response that arrived earlier on the other ring, so it covers every node except the originator. A small table indexed by tag remembers, for each snoop still in flight, whether it has been seen on the other ring and what response came with it. When the local directory can supply the data, the node raises an intermediate data response on the first arrival. That response names the ring that reaches the requester in fewer hops.

Top module: `dual_ring_resp_combiner`

## Requirements
- R1: A launch puts one snoop on both rings in the next cycle. Each copy carries origin equal to NODE_ID, response 00 and the final flag at 0.
- R2: Responses are 2-bit codes: 00 miss, 01 shared hit, 10 exclusive hit, 11 retry. A merge keeps the numerically larger code, so retry dominates everything.
- R3: On the first arrival of a tag, the node forwards on that ring the merge of the incoming response and its local response, with the final flag at 0.
- R4: On the second arrival of a tag, the node forwards the merge of the incoming response, its local response and the incoming response captured at the first arrival, with the final flag at 1. This equals the merge over all nodes other than the origin.
- R5: When one tag arrives on both rings in the same cycle, ring 0 is treated as the first arrival and ring 1 as the second.
- R6: A snoop whose origin equals NODE_ID is not forwarded. One cycle after it arrives, the completion output on that ring shows its tag and the incoming response unchanged.
- R7: A forwarded snoop keeps its tag, origin and address, and appears on the output of the same ring exactly one cycle after it arrives.
- R8: The intermediate data output of a ring pulses one cycle after a first arrival whose local response is 01 or 10. It carries the tag, with the destination equal to the origin. It does not pulse on a second arrival or for codes 00 and 11.
- R9: The return ring is 0 when the distance (dst − src) mod NODES is no larger than (src − dst) mod NODES, and 1 otherwise. Here src is this node and dst is the requester.
- R10: After reset, no valid, completion or intermediate data output is asserted, and no tag is marked as seen.
- R11: Two different tags may arrive on the two rings in the same cycle. Each is handled with no effect on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| lau_vld | input | 1 | Start a snoop from this node |
| lau_tag | input | TAG_W | Tag of the started snoop |
| lau_addr | input | ADDR_W | Address of the started snoop |
| rx_vld | input | 2 | Snoop arriving, one bit per ring |
| rx_tag | input | 2×TAG_W | Arriving tag per ring |
| rx_org | input | 2×NODE_W | Arriving origin node per ring |
| rx_addr | input | 2×ADDR_W | Arriving address per ring |
| rx_resp | input | 2×2 | Arriving partial response per ring |
| dir_resp | input | 2×2 | Local directory answer for the snoop arriving on each ring |
| tx_vld | output | 2 | Snoop leaving, one bit per ring |
| tx_tag | output | 2×TAG_W | Leaving tag per ring |
| tx_org | output | 2×NODE_W | Leaving origin per ring |
| tx_addr | output | 2×ADDR_W | Leaving address per ring |
| tx_resp | output | 2×2 | Leaving merged response per ring |
| tx_fin | output | 2 | 1 marks a final response, 0 an early one |
| cmp_vld | output | 2 | Own snoop returned on that ring |
| cmp_tag | output | 2×TAG_W | Tag of the returned snoop |
| cmp_resp | output | 2×2 | Full response of the returned snoop |
| idr_vld | output | 2 | Intermediate data response, per ring of arrival |
| idr_tag | output | 2×TAG_W | Tag for the data return |
| idr_dst | output | 2×NODE_W | Requester node for the data return |
| idr_ring | output | 2 | Ring chosen for the data return |

## Verification
The assertions take three things for granted. No snoop arrives for forwarding in a cycle in which this node launches one. A tag names at most one snoop in flight across the whole system. The local directory gives the same answer for a tag on both arrivals. The bench connects four nodes into a real pair of rings. It launches only when the rings are idle, or in the same cycle from nodes whose paths cannot meet their own launch slots. It draws each node's directory answer from a table keyed by tag, so both arrivals see one value.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef logic [1:0] resp_t;
  typedef int unsigned uint_t;

  localparam resp_t RSP_MISS = 2'b00;
  localparam resp_t RSP_SHR  = 2'b01;
  localparam resp_t RSP_EXC  = 2'b10;
  localparam resp_t RSP_RTY  = 2'b11;

  // priority merge: larger code wins, retry on top
  function automatic resp_t resp_merge(resp_t a, resp_t b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic is_data_hit(resp_t r);
    return (r == RSP_SHR) || (r == RSP_EXC);
  endfunction

  // hops needed moving in the increasing direction
  function automatic uint_t ring_dist(uint_t from, uint_t to, uint_t nodes);
    return (to + nodes - from) % nodes;
  endfunction

  // 0 = increasing-index ring, 1 = decreasing; tie to ring 0
  function automatic logic pick_ring(uint_t src, uint_t dst, uint_t nodes);
    uint_t cw;
    uint_t ccw;
    cw  = ring_dist(src, dst, nodes);
    ccw = ring_dist(dst, src, nodes);
    return (cw <= ccw) ? 1'b0 : 1'b1;
  endfunction
endpackage

// File: rtl/snoop_tag_tracker.sv
module snoop_tag_tracker
  import dr_pkg::*;
#(
  parameter int TAG_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            arr_vld,
  input  logic [1:0][TAG_W-1:0] arr_tag,
  input  resp_t [1:0]           arr_resp,
  output logic [1:0]            fin,
  output resp_t [1:0]           other_part
);
  localparam int TAGS = 1 << TAG_W;

  logic [TAGS-1:0] seen;
  resp_t           part [TAGS];
  logic            same_tag;

  assign same_tag = arr_vld[0] && arr_vld[1] && (arr_tag[0] == arr_tag[1])
                    && !seen[arr_tag[0]];

  assign fin[0] = arr_vld[0] && seen[arr_tag[0]];
  assign fin[1] = arr_vld[1] && (seen[arr_tag[1]] || same_tag);

  assign other_part[0] = part[arr_tag[0]];
  assign other_part[1] = same_tag ? arr_resp[0] : part[arr_tag[1]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
      for (int t = 0; t < TAGS; t++) part[t] <= RSP_MISS;
    end else begin
      for (int r = 0; r < 2; r++) begin
        if (arr_vld[r]) begin
          if (fin[r]) begin
            seen[arr_tag[r]] <= 1'b0;
          end else if (!same_tag) begin
            seen[arr_tag[r]] <= 1'b1;
            part[arr_tag[r]] <= arr_resp[r];
          end
        end
      end
    end
  end

  // R3: a lone first arrival leaves its tag marked for the other ring
  a_r3_first_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_vld[0] && !fin[0] && !same_tag) |=> seen[$past(arr_tag[0])]);
  // R4: the second arrival retires the tag
  a_r4_second_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_vld[1] && fin[1] && !(arr_vld[0] && !fin[0] && arr_tag[0] == arr_tag[1]))
    |=> !seen[$past(arr_tag[1])]);
  // R5: a same-cycle pair splits early on ring 0, final on ring 1
  a_r5_pair_split: assert property (@(posedge clk) disable iff (!rst_n)
    same_tag |-> (!fin[0] && fin[1]));
endmodule

// File: rtl/ring_hop_stage.sv
module ring_hop_stage
  import dr_pkg::*;
#(
  parameter int NODES   = 4,
  parameter int NODE_ID = 0,
  parameter int TAG_W   = 2,
  parameter int NODE_W  = 2,
  parameter int ADDR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lau_vld,
  input  logic [TAG_W-1:0]  lau_tag,
  input  logic [ADDR_W-1:0] lau_addr,
  input  logic              rx_vld,
  input  logic [TAG_W-1:0]  rx_tag,
  input  logic [NODE_W-1:0] rx_org,
  input  logic [ADDR_W-1:0] rx_addr,
  input  resp_t             rx_resp,
  input  resp_t             dir_resp,
  input  logic              fin,
  input  resp_t             other_part,
  output logic              arrive,
  output logic              tx_vld,
  output logic [TAG_W-1:0]  tx_tag,
  output logic [NODE_W-1:0] tx_org,
  output logic [ADDR_W-1:0] tx_addr,
  output resp_t             tx_resp,
  output logic              tx_fin,
  output logic              cmp_vld,
  output logic [TAG_W-1:0]  cmp_tag,
  output resp_t             cmp_resp,
  output logic              idr_vld,
  output logic [TAG_W-1:0]  idr_tag,
  output logic [NODE_W-1:0] idr_dst,
  output logic              idr_ring
);
  localparam logic [NODE_W-1:0] SELF = NODE_W'(NODE_ID);

  logic  own_ret;
  logic  idr_fire;
  resp_t fwd_resp;

  assign own_ret  = rx_vld && (rx_org == SELF);
  assign arrive   = rx_vld && !own_ret;
  assign fwd_resp = resp_merge(resp_merge(rx_resp, dir_resp),
                               fin ? other_part : RSP_MISS);
  assign idr_fire = arrive && !fin && is_data_hit(dir_resp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_vld   <= 1'b0;
      cmp_vld  <= 1'b0;
      idr_vld  <= 1'b0;
      tx_tag   <= '0;
      tx_org   <= '0;
      tx_addr  <= '0;
      tx_resp  <= RSP_MISS;
      tx_fin   <= 1'b0;
      cmp_tag  <= '0;
      cmp_resp <= RSP_MISS;
      idr_tag  <= '0;
      idr_dst  <= '0;
      idr_ring <= 1'b0;
    end else begin
      tx_vld  <= lau_vld || arrive;
      cmp_vld <= own_ret;
      idr_vld <= idr_fire;
      if (lau_vld) begin
        tx_tag  <= lau_tag;
        tx_org  <= SELF;
        tx_addr <= lau_addr;
        tx_resp <= RSP_MISS;
        tx_fin  <= 1'b0;
      end else if (arrive) begin
        tx_tag  <= rx_tag;
        tx_org  <= rx_org;
        tx_addr <= rx_addr;
        tx_resp <= fwd_resp;
        tx_fin  <= fin;
      end
      if (own_ret) begin
        cmp_tag  <= rx_tag;
        cmp_resp <= rx_resp;
      end
      if (idr_fire) begin
        idr_tag  <= rx_tag;
        idr_dst  <= rx_org;
        idr_ring <= pick_ring(uint_t'(NODE_ID), uint_t'(rx_org), uint_t'(NODES));
      end
    end
  end

  // R1: input rule, the launch slot is never shared with a forward
  a_r1_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    !(lau_vld && arrive));
  a_r1_launch_clean: assert property (@(posedge clk) disable iff (!rst_n)
    lau_vld |=> (tx_vld && tx_org == SELF && tx_resp == RSP_MISS && !tx_fin));
  a_r2_merge_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive && !lau_vld) |=> (tx_resp >= $past(rx_resp) && tx_resp >= $past(dir_resp)));
  a_r6_own_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (own_ret && !lau_vld) |=> (!tx_vld && cmp_vld && cmp_resp == $past(rx_resp)));
  a_r7_fields_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive && !lau_vld) |=> (tx_tag == $past(rx_tag) && tx_org == $past(rx_org)
                              && tx_addr == $past(rx_addr)));
  a_r8_idr_early_only: assert property (@(posedge clk) disable iff (!rst_n)
    idr_vld |-> (tx_vld && !tx_fin && idr_tag == tx_tag));
endmodule

// File: rtl/dual_ring_resp_combiner.sv
module dual_ring_resp_combiner
  import dr_pkg::*;
#(
  parameter int NODES   = 4,
  parameter int NODE_ID = 0,
  parameter int TAG_W   = 2,
  parameter int ADDR_W  = 16,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lau_vld,
  input  logic [TAG_W-1:0]       lau_tag,
  input  logic [ADDR_W-1:0]      lau_addr,
  input  logic [1:0]             rx_vld,
  input  logic [1:0][TAG_W-1:0]  rx_tag,
  input  logic [1:0][NODE_W-1:0] rx_org,
  input  logic [1:0][ADDR_W-1:0] rx_addr,
  input  logic [1:0][1:0]        rx_resp,
  input  logic [1:0][1:0]        dir_resp,
  output logic [1:0]             tx_vld,
  output logic [1:0][TAG_W-1:0]  tx_tag,
  output logic [1:0][NODE_W-1:0] tx_org,
  output logic [1:0][ADDR_W-1:0] tx_addr,
  output logic [1:0][1:0]        tx_resp,
  output logic [1:0]             tx_fin,
  output logic [1:0]             cmp_vld,
  output logic [1:0][TAG_W-1:0]  cmp_tag,
  output logic [1:0][1:0]        cmp_resp,
  output logic [1:0]             idr_vld,
  output logic [1:0][TAG_W-1:0]  idr_tag,
  output logic [1:0][NODE_W-1:0] idr_dst,
  output logic [1:0]             idr_ring
);
  logic [1:0]  arrive;
  logic [1:0]  fin;
  resp_t [1:0] other_part;

  snoop_tag_tracker #(.TAG_W(TAG_W)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arr_vld    (arrive),
    .arr_tag    (rx_tag),
    .arr_resp   (rx_resp),
    .fin        (fin),
    .other_part (other_part)
  );

  for (genvar r = 0; r < 2; r++) begin : g_ring
    ring_hop_stage #(
      .NODES(NODES), .NODE_ID(NODE_ID), .TAG_W(TAG_W),
      .NODE_W(NODE_W), .ADDR_W(ADDR_W)
    ) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .lau_vld    (lau_vld),
      .lau_tag    (lau_tag),
      .lau_addr   (lau_addr),
      .rx_vld     (rx_vld[r]),
      .rx_tag     (rx_tag[r]),
      .rx_org     (rx_org[r]),
      .rx_addr    (rx_addr[r]),
      .rx_resp    (rx_resp[r]),
      .dir_resp   (dir_resp[r]),
      .fin        (fin[r]),
      .other_part (other_part[r]),
      .arrive     (arrive[r]),
      .tx_vld     (tx_vld[r]),
      .tx_tag     (tx_tag[r]),
      .tx_org     (tx_org[r]),
      .tx_addr    (tx_addr[r]),
      .tx_resp    (tx_resp[r]),
      .tx_fin     (tx_fin[r]),
      .cmp_vld    (cmp_vld[r]),
      .cmp_tag    (cmp_tag[r]),
      .cmp_resp   (cmp_resp[r]),
      .idr_vld    (idr_vld[r]),
      .idr_tag    (idr_tag[r]),
      .idr_dst    (idr_dst[r]),
      .idr_ring   (idr_ring[r])
    );
  end

  // R11: two different tags handled in one cycle keep separate roles
  a_r11_split_tags: assert property (@(posedge clk) disable iff (!rst_n)
    (fin[0] && fin[1]) |-> (rx_tag[0] != rx_tag[1]));
endmodule

// File: tb/tb_dual_ring_resp_combiner.sv
module tb_dual_ring_resp_combiner;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int TW = 2;
  localparam int AW = 16;
  localparam int NW = 2;
  localparam int TAGS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]          tx_vld   [N];
  logic [1:0][TW-1:0]  tx_tag   [N];
  logic [1:0][NW-1:0]  tx_org   [N];
  logic [1:0][AW-1:0]  tx_addr  [N];
  logic [1:0][1:0]     tx_resp  [N];
  logic [1:0]          tx_fin   [N];
  logic [1:0]          cmp_vld  [N];
  logic [1:0][TW-1:0]  cmp_tag  [N];
  logic [1:0][1:0]     cmp_resp [N];
  logic [1:0]          idr_vld  [N];
  logic [1:0][TW-1:0]  idr_tag  [N];
  logic [1:0][NW-1:0]  idr_dst  [N];
  logic [1:0]          idr_ring [N];
  logic                lau_vld  [N];
  logic [TW-1:0]       lau_tag  [N];
  logic [AW-1:0]       lau_addr [N];

  logic [1:0]  tbl     [TAGS][N];  // directory answer per tag, per node
  logic [AW-1:0] addr_of [TAGS];

  int n_chk = 0, n_fail = 0;
  int tx_cnt [TAGS];
  int cmp_cnt[TAGS];
  int idr_cnt[TAGS];
  bit done = 0;

  for (genvar g = 0; g < N; g++) begin : g_node
    localparam int PV = (g + N - 1) % N;  // feeds ring 0
    localparam int NX = (g + 1) % N;      // feeds ring 1
    logic [1:0][TW-1:0] rtag;
    logic [1:0][1:0]    dres;
    assign rtag    = {tx_tag[NX][1], tx_tag[PV][0]};
    assign dres[0] = tbl[rtag[0]][g];
    assign dres[1] = tbl[rtag[1]][g];
    dual_ring_resp_combiner #(.NODES(N), .NODE_ID(g), .TAG_W(TW), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n),
      .lau_vld(lau_vld[g]), .lau_tag(lau_tag[g]), .lau_addr(lau_addr[g]),
      .rx_vld ({tx_vld[NX][1],  tx_vld[PV][0]}),
      .rx_tag (rtag),
      .rx_org ({tx_org[NX][1],  tx_org[PV][0]}),
      .rx_addr({tx_addr[NX][1], tx_addr[PV][0]}),
      .rx_resp({tx_resp[NX][1], tx_resp[PV][0]}),
      .dir_resp(dres),
      .tx_vld(tx_vld[g]), .tx_tag(tx_tag[g]), .tx_org(tx_org[g]),
      .tx_addr(tx_addr[g]), .tx_resp(tx_resp[g]), .tx_fin(tx_fin[g]),
      .cmp_vld(cmp_vld[g]), .cmp_tag(cmp_tag[g]), .cmp_resp(cmp_resp[g]),
      .idr_vld(idr_vld[g]), .idr_tag(idr_tag[g]), .idr_dst(idr_dst[g]),
      .idr_ring(idr_ring[g])
    );
  end

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---- independent model ----
  function automatic int step(int n, int r);
    return (r == 0) ? (n + 1) % N : (n + N - 1) % N;
  endfunction

  function automatic int hops(int o, int g, int r);
    int n = o;
    int h = 0;
    while (n != g) begin n = step(n, r); h++; end
    return h;
  endfunction

  function automatic int prefix_resp(int t, int o, int g, int r);
    int n = o;
    int acc = 0;
    do begin
      n = step(n, r);
      if (int'(tbl[t][n]) > acc) acc = int'(tbl[t][n]);
    end while (n != g);
    return acc;
  endfunction

  function automatic int all_resp(int t, int o);
    int acc = 0;
    for (int n = 0; n < N; n++)
      if (n != o && int'(tbl[t][n]) > acc) acc = int'(tbl[t][n]);
    return acc;
  endfunction

  function automatic int short_ring(int src, int dst);
    return (hops(src, dst, 0) <= hops(src, dst, 1)) ? 0 : 1;
  endfunction

  // ---- output monitor ----
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int g = 0; g < N; g++) begin
        for (int r = 0; r < 2; r++) begin
          if (tx_vld[g][r]) begin
            int t, o, hr, ho, efin, ehit;
            t = int'(tx_tag[g][r]);
            o = int'(tx_org[g][r]);
            tx_cnt[t]++;
            check("R7", int'(tx_addr[g][r]), int'(addr_of[t]), "address carried");
            if (o == g) begin
              check("R1", int'(tx_resp[g][r]), 0, "launch response");
              check("R1", int'(tx_fin[g][r]), 0, "launch flag");
            end else begin
              hr = hops(o, g, r);
              ho = N - hr;
              efin = (hr > ho || (hr == ho && r == 1)) ? 1 : 0;
              if (hr == ho) check("R5", int'(tx_fin[g][r]), efin, "tie flag");
              else if (efin == 1) check("R4", int'(tx_fin[g][r]), 1, "final flag");
              else check("R3", int'(tx_fin[g][r]), 0, "early flag");
              if (efin == 1)
                check("R4 R2", int'(tx_resp[g][r]), all_resp(t, o), "final merge");
              else
                check("R3 R2", int'(tx_resp[g][r]), prefix_resp(t, o, g, r), "early merge");
              ehit = (efin == 0 && (tbl[t][g] == 2'b01 || tbl[t][g] == 2'b10)) ? 1 : 0;
              check("R8", int'(idr_vld[g][r]), ehit, "intermediate data pulse");
              if (idr_vld[g][r]) begin
                idr_cnt[t]++;
                check("R8", int'(idr_dst[g][r]), o, "data destination");
                check("R9", int'(idr_ring[g][r]), short_ring(g, o), "return ring");
              end
            end
          end else begin
            check("R8", int'(idr_vld[g][r]), 0, "pulse without forward");
          end
          if (cmp_vld[g][r]) begin
            int t;
            t = int'(cmp_tag[g][r]);
            cmp_cnt[t]++;
            check("R6", int'(cmp_resp[g][r]), all_resp(t, g), "returned response");
          end
        end
      end
    end
  end

  // ---- scenarios ----
  task automatic fire(int o1, int t1, int o2, int t2);
    @(negedge clk);
    lau_vld[o1] = 1'b1; lau_tag[o1] = TW'(t1); lau_addr[o1] = addr_of[t1];
    if (o2 >= 0) begin
      lau_vld[o2] = 1'b1; lau_tag[o2] = TW'(t2); lau_addr[o2] = addr_of[t2];
    end
    @(negedge clk);
    for (int n = 0; n < N; n++) lau_vld[n] = 1'b0;
    repeat (N + 4) @(negedge clk);
  endtask

  task automatic expect_counts(int t, int o, int tx0, int cmp0, int idr0, string req);
    int hits = 0;
    for (int n = 0; n < N; n++)
      if (n != o && (tbl[t][n] == 2'b01 || tbl[t][n] == 2'b10)) hits++;
    check("R6", tx_cnt[t] - tx0, 2 * N, "ring hops per snoop");
    check("R6", cmp_cnt[t] - cmp0, 2, "completions per snoop");
    check(req, idr_cnt[t] - idr0, hits, "intermediate data count");
  endtask

  task automatic run_one(int o, int t, string req);
    int a, b, c;
    a = tx_cnt[t]; b = cmp_cnt[t]; c = idr_cnt[t];
    fire(o, t, -1, 0);
    expect_counts(t, o, a, b, c, req);
  endtask

  task automatic t_reset;
    for (int g = 0; g < N; g++) begin
      check("R10", int'(tx_vld[g]), 0, "tx idle after reset");
      check("R10", int'(cmp_vld[g]), 0, "completion idle after reset");
      check("R10", int'(idr_vld[g]), 0, "data response idle after reset");
    end
  endtask

  task automatic t_basic;
    tbl[0][0] = 2'b00; tbl[0][1] = 2'b01; tbl[0][2] = 2'b00; tbl[0][3] = 2'b10;
    run_one(0, 0, "R8");
  endtask

  task automatic t_retry;
    tbl[1][0] = 2'b11; tbl[1][1] = 2'b10; tbl[1][2] = 2'b00; tbl[1][3] = 2'b01;
    run_one(2, 1, "R2");
  endtask

  task automatic t_allmiss;
    for (int n = 0; n < N; n++) tbl[2][n] = 2'b00;
    run_one(3, 2, "R8");
  endtask

  task automatic t_concurrent;  // R11
    int a2, b2, c2, a3, b3, c3;
    tbl[2][0] = 2'b00; tbl[2][1] = 2'b10; tbl[2][2] = 2'b01; tbl[2][3] = 2'b00;
    tbl[3][0] = 2'b01; tbl[3][1] = 2'b11; tbl[3][2] = 2'b00; tbl[3][3] = 2'b10;
    a2 = tx_cnt[2]; b2 = cmp_cnt[2]; c2 = idr_cnt[2];
    a3 = tx_cnt[3]; b3 = cmp_cnt[3]; c3 = idr_cnt[3];
    fire(0, 2, 2, 3);
    expect_counts(2, 0, a2, b2, c2, "R11");
    expect_counts(3, 2, a3, b3, c3, "R11");
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 16; i++) begin
      int t;
      t = i % TAGS;
      for (int n = 0; n < N; n++) tbl[t][n] = 2'($urandom_range(0, 3));
      run_one(i % N, t, "R8");
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    for (int t = 0; t < TAGS; t++) begin
      addr_of[t] = AW'(16'h1a30 + 16'h0111 * t);
      tx_cnt[t] = 0; cmp_cnt[t] = 0; idr_cnt[t] = 0;
      for (int n = 0; n < N; n++) tbl[t][n] = 2'b00;
    end
    for (int n = 0; n < N; n++) begin
      lau_vld[n] = 1'b0; lau_tag[n] = '0; lau_addr[n] = '0;
    end
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_retry();
    t_allmiss();
    t_concurrent();
    t_sweep();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    summary();
    $finish;
  end
endmodule